// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is the two-wire serial target that gives a host access to the volatile configuration shadow of a programmable clock generator. It watches SCL and SDA, and it answers on SDA through an open-drain pad control: `sda_oe` high pulls the line low. It recognises its own 7-bit device address and carries out exactly one register access per transaction, either a one-byte write or a one-byte read. The shadow memory is a separate block. This block reaches it through a simple register port. A read-only identification byte is held inside the block.

The device address is not fixed. It is an input that the shadow configuration drives, and it holds 0x55 when the shadow keeps its default value. After reset the target answers nothing until a holdoff counter has expired. The length of the holdoff is a parameter, and it is sized for at least 5 ms at the system clock. Both bus lines pass through a two-flop synchroniser and a short glitch filter before START and STOP are decoded. Timing is budgeted for fast-mode SCL rates up to 400 kHz.

The register port has no back-pressure. The shadow must accept a write strobe in any cycle, and it must return read data on the cycle after a read strobe. The port carries only accesses that fall inside the mapped windows.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset, `sda_oe`, `shd_wr_en` and `shd_rd_en` are all low.
- R2: The target acknowledges an address byte only when its upper 7 bits equal `dev_addr`. After a mismatch it leaves SDA released until the next START.
- R3: Until HOLDOFF_CYCLES clocks have passed since reset, every address byte is NACKed and `sda_oe` stays low.
- R4: A write is START, address with R/W=0, register byte, data byte, STOP. Each of the three bytes is ACKed, and the data byte produces one `shd_wr_en` pulse carrying that register address and data.
- R5: Only one data byte is accepted per transaction. A second data byte is NACKed and is not written.
- R6: Register 0x00 always reads 0x51. A write to 0x00 is ACKed and produces no strobe.
- R7: The mapped windows are 0x10–0x15, 0x50–0x57 and 0xD4–0xD6. A write outside them is ACKed and produces no strobe. A read outside them returns 0x00.
- R8: A read is START, address with R/W=0, register byte, repeated START, address with R/W=1, then one data byte driven MSB first. For a mapped address the byte comes from the shadow.
- R9: A STOP at any point in a transaction abandons it. Nothing is written, and the next transaction behaves normally.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN clock cycles has no effect on the bytes received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_addr | input | 7 | Device address from the configuration shadow |
| shd_wr_en | output | 1 | Shadow write strobe |
| shd_rd_en | output | 1 | Shadow read strobe |
| shd_addr | output | 8 | Shadow register address |
| shd_wdata | output | 8 | Shadow write data |
| shd_rdata | input | 8 | Shadow read data, valid one cycle after `shd_rd_en` |

## Verification
Two events can meet in the same cycle: the holdoff counter expiring and the decision taken on the address acknowledge. The bench provokes this by starting a transaction so that its address byte ends just before the expiry, then replaying the same byte just after it. The first attempt must see SDA left high, with `sda_oe` never raised. The replay must be acknowledged and must complete its access. Both outcomes are judged at the pins, in the acknowledge slot.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 8;
  localparam logic [REG_AW-1:0] ID_ADDR  = 8'h00;
  localparam logic [REG_DW-1:0] ID_VALUE = 8'h51;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEVADR, ST_DEVACK, ST_REGADR, ST_REGACK,
    ST_WDATA, ST_WACK, ST_RDATA, ST_MACK, ST_PARK
  } tgt_state_e;

  typedef enum logic [1:0] {SRC_NONE, SRC_ID, SRC_SHD, SRC_ZERO} rd_src_e;

  function automatic logic in_shadow(input logic [REG_AW-1:0] a);
    return (a >= 8'h10 && a <= 8'h15) ||
           (a >= 8'h50 && a <= 8'h57) ||
           (a >= 8'hD4 && a <= 8'hD6);
  endfunction
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      lvl_o  <= 1'b1;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (sync_q[1] != lvl_o) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          lvl_o  <= sync_q[1];
          rise_o <= sync_q[1];
          fall_o <= ~sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  p_edge_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
endmodule

// File: rtl/i2c_holdoff.sv
module i2c_holdoff #(
  parameter int unsigned CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(CYCLES - 1)) done_o <= 1'b1;
    end
  end

  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              ready,
  input  logic [6:0]        dev_addr,
  input  logic [REG_DW-1:0] rd_byte,
  output logic              sda_oe,
  output logic              req_wr,
  output logic              req_rd,
  output logic [REG_AW-1:0] req_addr,
  output logic [REG_DW-1:0] req_data
);
  tgt_state_e        state_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        shreg_q;
  logic [REG_AW-1:0] ptr_q;
  logic              is_read_q;
  logic              wr_done_q;
  logic              start_det, stop_det, shifting;

  assign start_det = scl_lvl && sda_fall;
  assign stop_det  = scl_lvl && sda_rise;
  assign shifting  = (state_q == ST_DEVADR) || (state_q == ST_REGADR) ||
                     (state_q == ST_WDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      is_read_q <= 1'b0;
      wr_done_q <= 1'b0;
      sda_oe    <= 1'b0;
      req_wr    <= 1'b0;
      req_rd    <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      req_wr <= 1'b0;
      req_rd <= 1'b0;
      if (stop_det) begin
        state_q <= ST_IDLE;
        sda_oe  <= 1'b0;
      end else if (start_det) begin
        sda_oe    <= 1'b0;
        bitcnt_q  <= '0;
        wr_done_q <= 1'b0;
        state_q   <= ready ? ST_DEVADR : ST_PARK;
      end else if (shifting) begin
        if (scl_rise) begin
          shreg_q  <= {shreg_q[6:0], sda_lvl};
          bitcnt_q <= bitcnt_q + 1'b1;
        end else if (scl_fall && bitcnt_q == 4'd8) begin
          bitcnt_q <= '0;
          unique case (state_q)
            ST_DEVADR: begin
              if (shreg_q[7:1] == dev_addr && ready) begin
                sda_oe    <= 1'b1;
                is_read_q <= shreg_q[0];
                state_q   <= ST_DEVACK;
                if (shreg_q[0]) begin
                  req_rd   <= 1'b1;
                  req_addr <= ptr_q;
                end
              end else begin
                state_q <= ST_PARK;
              end
            end
            ST_REGADR: begin
              ptr_q   <= shreg_q;
              sda_oe  <= 1'b1;
              state_q <= ST_REGACK;
            end
            default: begin
              if (!wr_done_q) begin
                req_wr    <= 1'b1;
                req_addr  <= ptr_q;
                req_data  <= shreg_q;
                wr_done_q <= 1'b1;
                sda_oe    <= 1'b1;
                state_q   <= ST_WACK;
              end else begin
                state_q <= ST_PARK;
              end
            end
          endcase
        end
      end else begin
        unique case (state_q)
          ST_DEVACK: if (scl_fall) begin
            bitcnt_q <= '0;
            if (is_read_q) begin
              shreg_q <= rd_byte;
              sda_oe  <= ~rd_byte[7];
              state_q <= ST_RDATA;
            end else begin
              sda_oe  <= 1'b0;
              state_q <= ST_REGADR;
            end
          end
          ST_REGACK, ST_WACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            state_q <= ST_WDATA;
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt_q == 4'd8) begin
                sda_oe  <= 1'b0;
                state_q <= ST_MACK;
              end else begin
                sda_oe  <= ~shreg_q[6];
                shreg_q <= {shreg_q[6:0], 1'b0};
              end
            end
          end
          ST_MACK: if (scl_rise) state_q <= ST_PARK;
          default: ;
        endcase
      end
    end
  end

  p_park_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARK) |-> !sda_oe);
  p_holdoff_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !sda_oe);
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_wr, req_rd}));
  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |-> $past(!wr_done_q));
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !sda_oe));
endmodule

// File: rtl/cfg_reg_decode.sv
module cfg_reg_decode
  import i2c_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [REG_DW-1:0] req_data,
  output logic              shd_wr_en,
  output logic              shd_rd_en,
  output logic [REG_AW-1:0] shd_addr,
  output logic [REG_DW-1:0] shd_wdata,
  input  logic [REG_DW-1:0] shd_rdata,
  output logic [REG_DW-1:0] rd_byte
);
  rd_src_e src_q;
  logic    mapped;

  assign mapped    = in_shadow(req_addr);
  assign shd_wr_en = req_wr && mapped;
  assign shd_rd_en = req_rd && mapped;
  assign shd_addr  = req_addr;
  assign shd_wdata = req_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= SRC_NONE;
      rd_byte <= '0;
    end else begin
      src_q <= SRC_NONE;
      if (req_rd) begin
        if (req_addr == ID_ADDR) src_q <= SRC_ID;
        else if (mapped)         src_q <= SRC_SHD;
        else                     src_q <= SRC_ZERO;
      end
      unique case (src_q)
        SRC_ID:   rd_byte <= ID_VALUE;
        SRC_SHD:  rd_byte <= shd_rdata;
        SRC_ZERO: rd_byte <= '0;
        default:  ;
      endcase
    end
  end

  p_id_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_rd, 2) && $past(req_addr, 2) == ID_ADDR) |-> rd_byte == ID_VALUE);
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_rd, 2) && $past(req_addr, 2) != ID_ADDR && !in_shadow($past(req_addr, 2)))
      |-> rd_byte == '0);
  p_shd_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shd_rd_en, 2) |-> rd_byte == $past(shd_rdata));
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter int          FILT_LEN       = 3,
  parameter int unsigned HOLDOFF_CYCLES = 250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [6:0]  dev_addr,
  output logic        shd_wr_en,
  output logic        shd_rd_en,
  output logic [7:0]  shd_addr,
  output logic [7:0]  shd_wdata,
  input  logic [7:0]  shd_rdata
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] raw, lvl, rise, fall;
  logic              ready, req_wr, req_rd;
  logic [REG_AW-1:0] req_addr;
  logic [REG_DW-1:0] req_data, rd_byte;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw[g]),
      .lvl_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g]));
  end

  i2c_holdoff #(.CYCLES(HOLDOFF_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .done_o(ready));

  i2c_target_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
    .sda_lvl(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
    .ready(ready), .dev_addr(dev_addr), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_data(req_data));

  cfg_reg_decode u_dec (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_data(req_data),
    .shd_wr_en(shd_wr_en), .shd_rd_en(shd_rd_en),
    .shd_addr(shd_addr), .shd_wdata(shd_wdata),
    .shd_rdata(shd_rdata), .rd_byte(rd_byte));

  p_no_id_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shd_wr_en |-> shd_addr != ID_ADDR);
endmodule

// File: tb/i2c_cfg_target_test.sv
`timescale 1ns/1ps
module i2c_cfg_target_test;
  localparam int HOLD = 3000;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, shd_wr_en, shd_rd_en;
  logic [6:0] dev_addr = 7'h55;
  logic [7:0] shd_addr, shd_wdata, shd_rdata;
  logic sda_line;
  logic [7:0] mem [0:255];
  int total = 0, bad = 0, wr_cnt = 0, rd_cnt = 0, cyc = 0;
  bit oe_seen = 0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_cfg_target #(.FILT_LEN(3), .HOLDOFF_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_addr(dev_addr), .shd_wr_en(shd_wr_en), .shd_rd_en(shd_rd_en),
    .shd_addr(shd_addr), .shd_wdata(shd_wdata), .shd_rdata(shd_rdata));

  always @(posedge clk) begin
    if (shd_wr_en) mem[shd_addr] <= shd_wdata;
    if (shd_rd_en) shd_rdata <= mem[shd_addr];
  end
  always @(negedge clk) begin
    cyc++;
    if (shd_wr_en) wr_cnt++;
    if (shd_rd_en) rd_cnt++;
    if (sda_oe) oe_seen = 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; scl_m = 1; w(20); sda_m = 0; w(20); scl_m = 0; w(10); endtask
  task automatic i2c_rstart(); sda_m = 1; w(10); scl_m = 1; w(20); sda_m = 0; w(20); scl_m = 0; w(10); endtask
  task automatic i2c_stop(); sda_m = 0; w(10); scl_m = 1; w(20); sda_m = 1; w(20); endtask
  // glitch: 0 none, 1 one-cycle SCL dip, 2 one-cycle SDA dip (on a 1 bit)
  task automatic send_bit(input bit b, input int glitch);
    sda_m = b; w(10); scl_m = 1;
    if (glitch == 1) begin w(10); scl_m = 0; w(1); scl_m = 1; w(9); end
    else if (glitch == 2) begin w(10); sda_m = 0; w(1); sda_m = b; w(9); end
    else w(20);
    scl_m = 0; w(10);
  endtask
  task automatic send_byte(input logic [7:0] b, input int gbit, input int gk, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], (i == gbit) ? gk : 0);
    sda_m = 1; w(10); scl_m = 1; w(10); ack = !sda_line; w(10); scl_m = 0; w(10);
  endtask
  task automatic recv_byte(input bit nack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1; w(10); scl_m = 1; w(10); b = {b[6:0], sda_line}; w(10); scl_m = 0; w(10);
    end
    send_bit(nack, 0);
  endtask
  task automatic reg_write(input logic [6:0] da, input logic [7:0] ra, input logic [7:0] d,
                           output bit a0, output bit a1, output bit a2);
    i2c_start(); send_byte({da, 1'b0}, -1, 0, a0);
    if (a0) begin send_byte(ra, -1, 0, a1); send_byte(d, -1, 0, a2); end
    else begin a1 = 0; a2 = 0; end
    i2c_stop();
  endtask
  task automatic reg_read(input logic [7:0] ra, output logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    i2c_start(); send_byte({dev_addr, 1'b0}, -1, 0, a0); send_byte(ra, -1, 0, a1);
    i2c_rstart(); send_byte({dev_addr, 1'b1}, -1, 0, a2); recv_byte(1'b1, d);
    i2c_stop(); ok = a0 && a1 && a2;
  endtask

  task automatic t_reset();
    check(!sda_oe && !shd_wr_en && !shd_rd_en, "R1 reset outputs", {sda_oe, shd_wr_en, shd_rd_en}, 0);
  endtask
  task automatic t_holdoff();
    bit a;
    w(2400 - cyc);
    oe_seen = 0;
    i2c_start(); send_byte({7'h55, 1'b0}, -1, 0, a); i2c_stop();
    check(!a && !oe_seen && cyc < HOLD, "R3 early address NACK", a, 0);
    w(HOLD + 50 - cyc);
    i2c_start(); send_byte({7'h55, 1'b0}, -1, 0, a); i2c_stop();
    check(a, "R3 address ACK after holdoff", a, 1);
  endtask
  task automatic t_write_read();
    bit a0, a1, a2, ok; logic [7:0] d; int wc;
    wc = wr_cnt;
    reg_write(7'h55, 8'h12, 8'hA5, a0, a1, a2);
    check(a0 && a1 && a2, "R4 write ACKs", {a0, a1, a2}, 7);
    check(wr_cnt == wc + 1 && mem[8'h12] == 8'hA5, "R4 write strobe", mem[8'h12], 8'hA5);
    reg_read(8'h12, d, ok);
    check(ok && d == 8'hA5, "R8 read back 0x12", d, 8'hA5);
    reg_write(7'h55, 8'h53, 8'h3C, a0, a1, a2);
    reg_read(8'h53, d, ok);
    check(ok && d == 8'h3C, "R8 read back 0x53", d, 8'h3C);
  endtask
  task automatic t_id();
    bit a0, a1, a2, ok; logic [7:0] d; int wc;
    reg_read(8'h00, d, ok);
    check(ok && d == 8'h51, "R6 ID read", d, 8'h51);
    wc = wr_cnt;
    reg_write(7'h55, 8'h00, 8'hFF, a0, a1, a2);
    check(a2 && wr_cnt == wc, "R6 ID write dropped", wr_cnt - wc, 0);
    reg_read(8'h00, d, ok);
    check(d == 8'h51, "R6 ID after write", d, 8'h51);
  endtask
  task automatic t_unmapped();
    bit a0, a1, a2, ok; logic [7:0] d; int wc;
    logic [7:0] outs [5] = '{8'h30, 8'h16, 8'h4F, 8'hD7, 8'h0F};
    wc = wr_cnt;
    foreach (outs[i]) begin
      reg_write(7'h55, outs[i], 8'h77, a0, a1, a2);
      check(a0 && a1 && a2, "R7 unmapped write ACK", {a0, a1, a2}, 7);
    end
    check(wr_cnt == wc, "R7 unmapped writes dropped", wr_cnt - wc, 0);
    reg_read(8'hD7, d, ok);
    check(ok && d == 8'h00, "R7 unmapped read zero", d, 0);
    reg_write(7'h55, 8'h15, 8'h11, a0, a1, a2);
    reg_write(7'h55, 8'hD6, 8'h22, a0, a1, a2);
    check(mem[8'h15] == 8'h11 && mem[8'hD6] == 8'h22, "R7 window edges written", mem[8'hD6], 8'h22);
  endtask
  task automatic t_mismatch();
    bit a0, a1, a2, a3; int wc;
    wc = wr_cnt; oe_seen = 0;
    i2c_start(); send_byte({7'h22, 1'b0}, -1, 0, a0);
    send_byte(8'h12, -1, 0, a1); send_byte(8'h99, -1, 0, a2); i2c_stop();
    check(!a0 && !a1 && !a2 && !oe_seen && wr_cnt == wc, "R2 foreign address ignored", oe_seen, 0);
    dev_addr = 7'h3A;
    reg_write(7'h55, 8'h12, 8'h01, a0, a1, a2);
    check(!a0, "R2 old address NACK after change", a0, 0);
    reg_write(7'h3A, 8'h12, 8'h5A, a3, a1, a2);
    check(a3 && mem[8'h12] == 8'h5A, "R2 new address accepted", mem[8'h12], 8'h5A);
    dev_addr = 7'h55;
  endtask
  task automatic t_burst();
    bit a0, a1, a2, a3; int wc;
    wc = wr_cnt;
    i2c_start(); send_byte({7'h55, 1'b0}, -1, 0, a0); send_byte(8'h50, -1, 0, a1);
    send_byte(8'hC1, -1, 0, a2); send_byte(8'hC2, -1, 0, a3); i2c_stop();
    check(a2 && !a3, "R5 second data byte NACK", a3, 0);
    check(wr_cnt == wc + 1 && mem[8'h50] == 8'hC1 && mem[8'h51] != 8'hC2, "R5 one write only", wr_cnt - wc, 1);
  endtask
  task automatic t_stop_mid();
    bit a0, a1, a2; int wc;
    wc = wr_cnt;
    i2c_start(); send_byte({7'h55, 1'b0}, -1, 0, a0); send_byte(8'h54, -1, 0, a1);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 0);
    i2c_stop();
    check(wr_cnt == wc, "R9 abandoned write", wr_cnt - wc, 0);
    reg_write(7'h55, 8'h54, 8'h6E, a0, a1, a2);
    check(a0 && a1 && a2 && mem[8'h54] == 8'h6E, "R9 recovery after STOP", mem[8'h54], 8'h6E);
  endtask
  task automatic t_glitch();
    bit a0, a1, a2;
    i2c_start(); send_byte({7'h55, 1'b0}, -1, 0, a0); send_byte(8'h55, 3, 1, a1);
    send_byte(8'hB7, 5, 2, a2); i2c_stop();
    check(a0 && a1 && a2 && mem[8'h55] == 8'hB7, "R10 glitches rejected", mem[8'h55], 8'hB7);
  endtask

  initial begin
    foreach (mem[i]) mem[i] = 8'h00;
    shd_rdata = 8'h00;
    w(4); t_reset(); rst_n = 1'b1;
    t_holdoff();
    t_write_read();
    t_id();
    t_unmapped();
    t_mismatch();
    t_burst();
    t_stop_mid();
    t_glitch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule